// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block watches a 24-bit bus address together with the cycle's function code, transfer size, direction and strobes, and drives one active-low select line per channel. Each channel holds two configuration words. One gives the base address and the block size. The other gives the acknowledge timing, the address-space filter, the interrupt-level filter, the direction filter, the strobe choice, and the port width with its byte lane.

While a channel's select is active, the block counts wait states. It then returns an internal transfer acknowledge that is coded for the channel's port width. A channel can instead terminate at once, or leave the acknowledge to external logic.

Configuration is written through a simple write port: a channel index, a word select and a data word. All outputs are registered. Every result appears exactly one clock after the edge that samples the inputs causing it.

Top module: `chip_select_gen`

## Requirements
- R1: After reset every select output and both acknowledge lines are high (inactive). Every channel has its direction field at 00 (disabled), so no bus cycle selects it until it is configured.
- R2: The base word is `cfg_wdata[16:4]` = base address bits 23..11 and `cfg_wdata[3:0]` = size code k. Address bits 23 down to 11+k are compared with the base, and lower bits are ignored. Codes 12 to 15 all compare bit 23 only (k=0 is 2 KiB, k=6 is 128 KiB, k=8 is 512 KiB).
- R3: The direction field is option bits [10:9]. With `rw`=1 meaning read, 01 selects reads only, 10 selects writes only, 11 selects both, and 00 selects nothing.
- R4: The space field is option bits [5:4]: 00 CPU space, 01 user, 10 supervisor, 11 user or supervisor. Function codes 001 and 010 are user, 101 and 110 are supervisor, and 111 is CPU space. Codes 000, 011 and 100 never match.
- R5: The level field is option bits [8:6]. In a CPU-space cycle (fc=111), a nonzero level matches only when `addr[3:1]` equals it, and 000 matches any level. Outside CPU space the level field has no effect.
- R6: Port width is option bit 12 (1 = 16-bit) and the lane field is option bits [14:13] (bit 14 upper, bit 13 lower). An 8-bit port matches every address. A 16-bit port matches only when an enabled lane is used. The upper lane is used when `addr[0]`=0. The lower lane is used when `addr[0]`=1 or when `siz` is not 01 (byte).
- R7: Option bit 11 picks the strobe: 0 selects `as_n`, 1 selects `ds_n`. A channel's `cs_n` goes low one clock after an edge that samples its strobe low with all filters matching. It returns high one clock after an edge that samples the strobe high.
- R8: The timing field is option bits [3:0]. For a value n from 0 to 13, the acknowledge goes low n+1 clocks after the edge at which `cs_n` went low. It stays low until `cs_n` returns high.
- R9: Timing value 1110 gives fast termination: the acknowledge goes low at the same edge as `cs_n`.
- R10: Timing value 1111 leaves the acknowledge to external logic: the channel never drives `ack_n` low, while its `cs_n` still asserts.
- R11: `ack_n[1]` goes low for a 16-bit port and `ack_n[0]` goes low for an 8-bit port. The other bit stays high.
- R12: The wait count restarts on every new strobe assertion. After the strobe is negated for a single clock, the next cycle again waits the full count.
- R13: A write with `cfg_opt`=0 loads the base word and a write with `cfg_opt`=1 loads the option word of channel `cfg_ch`. The new value governs matching from the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_ch | input | CH_W | Channel index of the write |
| cfg_opt | input | 1 | 0 = base word, 1 = option word |
| cfg_wdata | input | 17 | Configuration data |
| addr | input | 24 | Bus address |
| fc | input | 3 | Function code of the cycle |
| siz | input | 2 | Transfer size (01 = byte) |
| rw | input | 1 | 1 = read, 0 = write |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | output | NUM_CH | Select per channel, active low |
| ack_n | output | 2 | Transfer acknowledge: bit 1 for 16-bit ports, bit 0 for 8-bit ports |

## Verification
Every output is a register, so a select is due one clock after the rising edge that samples its qualifying strobe. An acknowledge is due n+1 clocks after the select edge for n wait states, or at that same edge for fast termination. The bench holds a per-channel age counter that it advances at each rising edge and updates its expectations there. It then compares the outputs at the following falling edge, half a clock after they settle and before any input changes. Strobes are applied in a fixed order, first address then data, and removed in the reverse order. This places the select edges of the two strobe choices one clock apart, at known cycles.

// File: rtl/csg_pkg.sv
package csg_pkg;

  localparam int ADDR_W   = 24;
  localparam int BASE_LSB = 11;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int SIZE_W   = 4;
  localparam int CFG_W    = BASE_W + SIZE_W;
  localparam int TM_W     = 4;
  localparam int MAX_SIZE = BASE_W - 1;

  localparam logic [TM_W-1:0] TM_FAST = 4'he;
  localparam logic [TM_W-1:0] TM_EXT  = 4'hf;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] size;
  } base_cfg_t;

  typedef struct packed {
    logic [1:0]      lane;
    logic            port16;
    logic            use_ds;
    logic [1:0]      dir;
    logic [2:0]      level;
    logic [1:0]      space;
    logic [TM_W-1:0] tmode;
  } opt_cfg_t;

  localparam int OPT_W = $bits(opt_cfg_t);

  function automatic logic space_ok(input logic [1:0] sp, input logic [2:0] fcode);
    logic is_user, is_sup, is_cpu;
    is_user = (fcode == 3'b001) || (fcode == 3'b010);
    is_sup  = (fcode == 3'b101) || (fcode == 3'b110);
    is_cpu  = (fcode == 3'b111);
    case (sp)
      2'b00:   space_ok = is_cpu;
      2'b01:   space_ok = is_user;
      2'b10:   space_ok = is_sup;
      default: space_ok = is_user || is_sup;
    endcase
  endfunction

endpackage

// File: rtl/csg_regs.sv
module csg_regs
  import csg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [CH_W-1:0]               ch,
  input  logic                          opt_sel,
  input  logic [CFG_W-1:0]              wdata,
  output base_cfg_t [NUM_CH-1:0]        base_q,
  output opt_cfg_t  [NUM_CH-1:0]        opt_q
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit_ch;
    assign hit_ch = we && (ch == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        opt_q[g]  <= '0;
      end else if (hit_ch) begin
        if (opt_sel) opt_q[g]  <= opt_cfg_t'(wdata[OPT_W-1:0]);
        else         base_q[g] <= base_cfg_t'(wdata);
      end
    end
  end

endmodule

// File: rtl/csg_match.sv
module csg_match
  import csg_pkg::*;
(
  input  base_cfg_t         bcfg,
  input  opt_cfg_t          ocfg,
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [2:0]        addr_lvl,
  input  logic              addr_lsb,
  input  logic [2:0]        fc,
  input  logic [1:0]        siz,
  input  logic              rw,
  input  logic              as_n,
  input  logic              ds_n,
  output logic              hit
);

  logic [SIZE_W-1:0] size_eff;
  logic [BASE_W-1:0] bit_ok;
  logic addr_ok, dir_ok, lvl_ok, lane_ok, strobe_on;

  assign size_eff = (bcfg.size > SIZE_W'(MAX_SIZE)) ? SIZE_W'(MAX_SIZE) : bcfg.size;

  for (genvar i = 0; i < BASE_W; i++) begin : g_bit
    assign bit_ok[i] = (i < int'(size_eff)) || (addr_hi[i] == bcfg.base[i]);
  end

  assign addr_ok = &bit_ok;

  assign dir_ok = rw ? ocfg.dir[0] : ocfg.dir[1];

  assign lvl_ok = (ocfg.level == 3'b000) || (fc != 3'b111) || (addr_lvl == ocfg.level);

  always_comb begin
    if (!ocfg.port16) begin
      lane_ok = 1'b1;
    end else begin
      lane_ok = (ocfg.lane[1] && !addr_lsb) ||
                (ocfg.lane[0] && (addr_lsb || (siz != 2'b01)));
    end
  end

  assign strobe_on = ocfg.use_ds ? !ds_n : !as_n;

  assign hit = addr_ok && dir_ok && space_ok(ocfg.space, fc) && lvl_ok && lane_ok && strobe_on;

endmodule

// File: rtl/csg_timer.sv
module csg_timer
  import csg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  opt_cfg_t ocfg,
  output logic     cs_n,
  output logic     ack16_n,
  output logic     ack8_n
);

  logic            active;
  logic [TM_W-1:0] cnt;
  logic            is_fast, is_counted, ack_go;

  assign is_fast    = (ocfg.tmode == TM_FAST);
  assign is_counted = (ocfg.tmode != TM_FAST) && (ocfg.tmode != TM_EXT);
  assign ack_go     = hit && (is_fast || (active && is_counted && (cnt == '0)));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      cs_n    <= 1'b1;
      ack16_n <= 1'b1;
      ack8_n  <= 1'b1;
    end else begin
      cs_n    <= !hit;
      ack16_n <= !(ack_go && ocfg.port16);
      ack8_n  <= !(ack_go && !ocfg.port16);
      if (!hit) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (!active) begin
        active <= 1'b1;
        cnt    <= ocfg.tmode;
      end else if (cnt != '0) begin
        cnt <= cnt - TM_W'(1);
      end
    end
  end

endmodule

// File: rtl/chip_select_gen.sv
module chip_select_gen
  import csg_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic              cfg_opt,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        fc,
  input  logic [1:0]        siz,
  input  logic              rw,
  input  logic              as_n,
  input  logic              ds_n,
  output logic [NUM_CH-1:0] cs_n,
  output logic [1:0]        ack_n
);

  base_cfg_t [NUM_CH-1:0] base_q;
  opt_cfg_t  [NUM_CH-1:0] opt_q;
  logic [NUM_CH-1:0] hit, a16_n, a8_n;
  logic unused_addr_mid;

  assign unused_addr_mid = ^addr[BASE_LSB-1:4];

  csg_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .ch(cfg_ch), .opt_sel(cfg_opt),
    .wdata(cfg_wdata), .base_q(base_q), .opt_q(opt_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    csg_match u_match (
      .bcfg(base_q[g]), .ocfg(opt_q[g]), .addr_hi(addr[ADDR_W-1:BASE_LSB]),
      .addr_lvl(addr[3:1]), .addr_lsb(addr[0]), .fc(fc), .siz(siz), .rw(rw),
      .as_n(as_n), .ds_n(ds_n), .hit(hit[g])
    );
    csg_timer u_timer (
      .clk(clk), .rst(rst), .hit(hit[g]), .ocfg(opt_q[g]),
      .cs_n(cs_n[g]), .ack16_n(a16_n[g]), .ack8_n(a8_n[g])
    );
  end

  assign ack_n = {&a16_n, &a8_n};

endmodule

// File: rtl/csg_checker.sv
module csg_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              as_n,
  input logic              ds_n,
  input logic [NUM_CH-1:0] cs_n,
  input logic [1:0]        ack_n
);

  // R1: the cycle after a reset edge shows every output inactive
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> ((&cs_n) && (ack_n == 2'b11)));

  // R7: a select can only follow an edge that saw some strobe low
  p_cs_needs_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n)) |-> $past(!as_n || !ds_n));

  // R7: both strobes high releases every select one clock later
  p_cs_release_r7: assert property (@(posedge clk) disable iff (rst)
    (as_n && ds_n) |=> (&cs_n));

  // R8: an acknowledge is never seen without a select
  p_ack_with_cs_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_n != 2'b11) |-> (!(&cs_n)));

  // R12: both strobes high also drops any acknowledge one clock later
  p_ack_release_r12: assert property (@(posedge clk) disable iff (rst)
    (as_n && ds_n) |=> (ack_n == 2'b11));

endmodule

bind chip_select_gen csg_checker #(.NUM_CH(NUM_CH)) u_csg_checker (
  .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .cs_n(cs_n), .ack_n(ack_n)
);

// File: tb/test_chip_select_gen.sv
`timescale 1ns/1ps
module test_chip_select_gen;

  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_ch = '0;
  logic        cfg_opt = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [23:0] addr = '0;
  logic [2:0]  fc = 3'b101;
  logic [1:0]  siz = 2'b10;
  logic        rw = 1'b1;
  logic        as_n = 1'b1;
  logic        ds_n = 1'b1;
  logic [NCH-1:0] cs_n;
  logic [1:0]  ack_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  int m_base [NCH];
  int m_opt  [NCH];
  int m_age  [NCH];
  bit m_prev [NCH];
  logic [NCH-1:0] exp_cs = '1;
  logic [1:0]     exp_ack = 2'b11;

  always #5 clk = ~clk;

  chip_select_gen #(.NUM_CH(NCH)) i_chip_select_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_opt(cfg_opt),
    .cfg_wdata(cfg_wdata), .addr(addr), .fc(fc), .siz(siz), .rw(rw),
    .as_n(as_n), .ds_n(ds_n), .cs_n(cs_n), .ack_n(ack_n)
  );

  function automatic bit m_hit(int c);
    int b, o, sz, lsb, tm, sp, ip, dirf, dsel, p16, ln, a, f;
    bit up, lo;
    b = m_base[c]; o = m_opt[c]; a = int'(addr); f = int'(fc);
    sz = b & 15; if (sz > 12) sz = 12;
    lsb = 11 + sz;
    if ((a >> lsb) != ((((b >> 4) << 11)) >> lsb)) return 0;
    tm = o & 15; sp = (o >> 4) & 3; ip = (o >> 6) & 7; dirf = (o >> 9) & 3;
    dsel = (o >> 11) & 1; p16 = (o >> 12) & 1; ln = (o >> 13) & 3;
    if (rw && (dirf & 1) == 0) return 0;
    if (!rw && (dirf & 2) == 0) return 0;
    case (sp)
      0: if (f != 7) return 0;
      1: if (!(f == 1 || f == 2)) return 0;
      2: if (!(f == 5 || f == 6)) return 0;
      default: if (!(f == 1 || f == 2 || f == 5 || f == 6)) return 0;
    endcase
    if (f == 7 && ip != 0 && ((a >> 1) & 7) != ip) return 0;
    if (p16 == 1) begin
      up = (a & 1) == 0;
      lo = ((a & 1) == 1) || (siz != 2'b01);
      if (!(((ln & 2) != 0 && up) || ((ln & 1) != 0 && lo))) return 0;
    end
    if (dsel == 1) return ds_n == 1'b0;
    return as_n == 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_base[c] = 0; m_opt[c] = 0; m_age[c] = 0; m_prev[c] = 0;
      end
      exp_cs = '1; exp_ack = 2'b11;
    end else begin
      exp_ack = 2'b11;
      for (int c = 0; c < NCH; c++) begin
        bit h, ak;
        int tm;
        h = m_hit(c);
        tm = m_opt[c] & 15;
        ak = 0;
        if (h) begin
          m_age[c] = m_prev[c] ? m_age[c] + 1 : 0;
          ak = (tm == 14) || (tm <= 13 && m_age[c] >= tm + 1);
        end else begin
          m_age[c] = 0;
        end
        m_prev[c] = h;
        exp_cs[c] = !h;
        if (ak) begin
          if (((m_opt[c] >> 12) & 1) == 1) exp_ack[1] = 1'b0;
          else exp_ack[0] = 1'b0;
        end
      end
      if (cfg_we) begin
        if (cfg_opt) m_opt[int'(cfg_ch)] = int'(cfg_wdata) & 32'h7fff;
        else m_base[int'(cfg_ch)] = int'(cfg_wdata);
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (cs_n !== exp_cs || ack_n !== exp_ack) begin
        errors++;
        $display("FAIL %s cycle %0d: cs_n=%b ack_n=%b expected cs_n=%b ack_n=%b",
                 cur_req, cycles, cs_n, ack_n, exp_cs, exp_ack);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [16:0] mk_base(int a, int sz);
    return 17'(((a >> 11) << 4) | sz);
  endfunction

  function automatic logic [16:0] mk_opt(int tm, int sp, int ip, int dirf,
                                         int dsel, int p16, int ln);
    return 17'(tm | (sp << 4) | (ip << 6) | (dirf << 9) | (dsel << 11) |
               (p16 << 12) | (ln << 13));
  endfunction

  task automatic wr(int ch, bit o, logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 1'(ch); cfg_opt = o; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(int a, int f, int s, bit r, int n);
    @(negedge clk);
    addr = 24'(a); fc = 3'(f); siz = 2'(s); rw = r; as_n = 1'b0;
    @(negedge clk);
    ds_n = 1'b0;
    repeat (n) @(negedge clk);
    ds_n = 1'b1;
    @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    cur_req = "R1";
    checks++;
    if (cs_n !== '1 || ack_n !== 2'b11) begin
      errors++;
      $display("FAIL R1 reset: cs_n=%b ack_n=%b expected all high", cs_n, ack_n);
    end
    bus(0, 5, 2, 1, 3);

    cur_req = "R13";
    wr(0, 0, mk_base(24'h123800, 0));
    wr(0, 1, mk_opt(0, 3, 0, 3, 0, 0, 0));
    bus(24'h1238FF, 5, 2, 1, 3);
    wr(0, 1, mk_opt(0, 3, 0, 0, 0, 0, 0));
    bus(24'h1238FF, 5, 2, 1, 3);
    wr(0, 1, mk_opt(0, 3, 0, 3, 0, 0, 0));

    cur_req = "R2";
    bus(24'h123000, 5, 2, 1, 2);
    bus(24'h123FFF, 1, 2, 0, 2);
    wr(0, 0, mk_base(24'h123800, 6));
    bus(24'h13FFFF, 5, 2, 1, 2);
    bus(24'h140000, 5, 2, 1, 2);
    bus(24'h120000, 5, 2, 1, 2);
    wr(0, 0, mk_base(24'h123800, 8));
    bus(24'h100000, 5, 2, 1, 2);
    bus(24'h180000, 5, 2, 1, 2);
    wr(0, 0, mk_base(24'h800000, 12));
    bus(24'hFFFFFF, 5, 2, 1, 2);
    bus(24'h7FFFFF, 5, 2, 1, 2);
    wr(0, 0, mk_base(24'h800000, 15));
    bus(24'hC00001, 5, 2, 1, 2);
    bus(24'h000001, 5, 2, 1, 2);

    cur_req = "R3";
    wr(0, 0, mk_base(24'h000000, 0));
    for (int d = 0; d < 4; d++) begin
      wr(0, 1, mk_opt(0, 3, 0, d, 0, 0, 0));
      bus(24'h10, 5, 2, 1, 2);
      bus(24'h10, 5, 2, 0, 2);
    end

    cur_req = "R4";
    for (int sp = 0; sp < 4; sp++) begin
      wr(0, 1, mk_opt(0, sp, 0, 3, 0, 0, 0));
      for (int f = 0; f < 8; f++) bus(24'h20, f, 2, 1, 1);
    end

    cur_req = "R5";
    wr(0, 1, mk_opt(0, 0, 3, 3, 0, 0, 0));
    for (int lv = 0; lv < 8; lv++) bus(lv << 1, 7, 2, 1, 1);
    wr(0, 1, mk_opt(0, 0, 0, 3, 0, 0, 0));
    bus(24'h0A, 7, 2, 1, 1);
    wr(0, 1, mk_opt(0, 3, 5, 3, 0, 0, 0));
    bus(24'h02, 5, 2, 1, 1);
    bus(24'h0A, 1, 2, 1, 1);

    cur_req = "R6";
    for (int ln = 0; ln < 4; ln++) begin
      wr(0, 1, mk_opt(0, 3, 0, 3, 0, 1, ln));
      bus(24'h40, 5, 1, 1, 2);
      bus(24'h41, 5, 1, 1, 2);
      bus(24'h40, 5, 2, 1, 2);
    end
    wr(0, 1, mk_opt(0, 3, 0, 3, 0, 0, 0));
    bus(24'h41, 5, 1, 1, 2);

    cur_req = "R7";
    wr(0, 1, mk_opt(0, 3, 0, 3, 1, 0, 0));
    bus(24'h50, 5, 2, 1, 3);
    bus(24'h50, 5, 2, 1, 0);
    wr(0, 1, mk_opt(14, 3, 0, 3, 0, 0, 0));
    bus(24'h50, 5, 2, 1, 3);

    cur_req = "R8";
    wr(0, 1, mk_opt(0, 3, 0, 3, 0, 0, 0));
    bus(24'h60, 5, 2, 1, 6);
    wr(0, 1, mk_opt(1, 3, 0, 3, 0, 0, 0));
    bus(24'h60, 5, 2, 1, 6);
    wr(0, 1, mk_opt(5, 3, 0, 3, 1, 0, 0));
    bus(24'h60, 5, 2, 1, 10);
    wr(0, 1, mk_opt(13, 3, 0, 3, 0, 0, 0));
    bus(24'h60, 5, 2, 1, 18);
    bus(24'h60, 5, 2, 1, 8);

    cur_req = "R9";
    wr(0, 1, mk_opt(14, 3, 0, 3, 1, 0, 0));
    bus(24'h70, 5, 2, 1, 4);

    cur_req = "R10";
    wr(0, 1, mk_opt(15, 3, 0, 3, 0, 0, 0));
    bus(24'h70, 5, 2, 1, 20);

    cur_req = "R11";
    wr(0, 1, mk_opt(2, 3, 0, 3, 0, 0, 0));
    wr(1, 0, mk_base(24'h400000, 4));
    wr(1, 1, mk_opt(2, 3, 0, 3, 0, 1, 3));
    bus(24'h400100, 5, 2, 1, 6);
    bus(24'h000100, 5, 2, 1, 6);
    wr(1, 1, mk_opt(14, 3, 0, 3, 1, 1, 2));
    bus(24'h400200, 5, 1, 0, 3);

    cur_req = "R12";
    wr(0, 1, mk_opt(3, 3, 0, 3, 0, 0, 0));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      addr = 24'h80; fc = 3'b101; rw = 1'b1; as_n = 1'b0; ds_n = 1'b0;
      repeat (6) @(negedge clk);
      as_n = 1'b1; ds_n = 1'b1;
    end
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule